// File: doc/BRIEF.md
# Grouped Pin Debouncer with Prescaler

This block cleans up sixteen slow external input pins before the rest of the chip sees them. The pins form two groups of eight. Each group has its own sampling-tick prescaler and its own choice of how many consecutive tick samples a new pin level must hold before it is accepted. Each pin first passes through a two-flop synchronizer. A small per-pin state machine then watches the synchronized level against the accepted level. It presents the accepted level and a one-cycle change pulse whenever the accepted level flips.

A single 32-bit configuration word holds both groups' divider codes, both sample-count selects, and the tick source select. The tick source is either the block clock itself or a slow strobe input, `lf_tick`, which counts once per high cycle. The word can be changed only while `enable` is low. While `enable` is low, the prescalers are held at zero and no validation is in progress. The accepted levels follow the synchronized pins directly and no change pulses are produced.

Each pin filter has two states. FLT_IDLE means that no validation is in progress. FLT_VERIFY means that a differing level is being counted. Four transitions connect them:
- **start**: in FLT_IDLE, a tick arrives while the sample differs. The filter moves to FLT_VERIFY with a count of 1.
- **abort**: in FLT_VERIFY, the sample matches the accepted level in any cycle. The filter returns to FLT_IDLE and the count clears.
- **accept**: in FLT_VERIFY, a tick brings the count to the required number. The level flips, a pulse is issued, and the filter returns to FLT_IDLE.
- **hold**: the filter stays in its state and the count advances on a tick.

Leaving `enable` forces FLT_IDLE.

Top module: `pin_debounce_top`

## Requirements
- R1: Pins 0 to 7 use the group 0 fields and pins 8 to 15 use the group 1 fields. Each group's settings affect only its own pins.
- R2: A group with divider code k (0 to 7) produces one sampling tick every 2^(k+1) source steps. The prescaler restarts from zero each time `enable` rises.
- R3: A group's sample select of 0 needs 3 ticks at the new level to accept a transition. A value of 1 needs 7.
- R4: Configuration word layout: bits 2:0 hold the group 0 code, bit 3 the group 0 sample select, bits 6:4 the group 1 code, bit 7 the group 1 sample select, and bit 16 the tick source select. All other bits read as 0.
- R5: After reset the configuration word reads 0, all levels are 0 and no change pulse is set.
- R6: A write with `cfg_we` high while `enable` is low is visible on `cfg_rdata` after the next edge. A write while `enable` is high leaves the word unchanged.
- R7: With source select 0, every clock cycle is a prescaler step. With source select 1, only cycles with `lf_tick` high are steps.
- R8: A raw pin change reaches the sampling logic after two clock edges. While disabled, it shows on `pins_level` after the third edge.
- R9: The validation count clears in any cycle where the synchronized level equals the accepted level. A pulse of fewer ticks than required, even when repeated, never flips the level.
- R10: `pins_change` for a pin is high for exactly the one cycle in which its accepted level has just flipped.
- R11: While `enable` is low, no change pulses occur and each accepted level follows its synchronized pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the debouncer and locks the configuration word |
| lf_tick | input | 1 | Slow step strobe used when the source select is 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| pins_in | input | 16 | Raw asynchronous pins |
| pins_level | output | 16 | Accepted debounced levels |
| pins_change | output | 16 | One-cycle pulse per pin when its level flips |

## Verification
The bench sweeps every divider code with both sample counts and both tick sources. It sets the two groups to opposite sample counts, so a design that mixed up group fields would flip pins at the wrong tick. Pins toggle at hold lengths from one tick period to eight. Holds just below the required count expose a counter that fails to clear: such a design would accept a glitch train. Code 7 checks that the mask covers the full 8-bit counter; a design that truncated it would tick far too often. Config writes while enabled, and the disabled path's three-edge latency, would show up as a wrong readback or an early or late level.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
    localparam int CODE_W       = 3;
    localparam int SAMPLES_FEW  = 3;
    localparam int SAMPLES_MANY = 7;
    localparam int SRC_SEL_BIT  = 16;
    localparam int GRP_FIELD_W  = CODE_W + 1;

    typedef struct packed {
        logic              many_samples;
        logic [CODE_W-1:0] div_code;
    } grp_cfg_t;

    typedef enum logic {
        FLT_IDLE   = 1'b0,
        FLT_VERIFY = 1'b1
    } flt_state_e;
endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pdb_prescaler.sv
module pdb_prescaler import pdb_pkg::*; #(
    parameter  int CODE_BITS = CODE_W,
    localparam int CNT_W     = 1 << CODE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 step,
    input  logic [CODE_BITS-1:0] code,
    output logic                 tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // Low (code+1) bits set: a wrap of that many bits marks the tick.
    assign mask = ~({CNT_W{1'b1}} << (int'(code) + 1));
    assign tick = enable && step && ((cnt_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pdb_pin_filter.sv
module pdb_pin_filter import pdb_pkg::*; #(
    parameter int CNT_W = $clog2(SAMPLES_MANY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic sample,
    input  logic many_samples,
    output logic level,
    output logic change
);
    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] need;
    logic             level_q, level_d;
    logic             change_q, change_d;

    assign need = many_samples ? CNT_W'(SAMPLES_MANY) : CNT_W'(SAMPLES_FEW);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FLT_IDLE;
            cnt_q    <= '0;
            level_q  <= 1'b0;
            change_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            level_q  <= level_d;
            change_q <= change_d;
        end
    end

    // Next state and next outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        level_d  = level_q;
        change_d = 1'b0;
        if (!enable) begin
            state_d = FLT_IDLE;
            cnt_d   = '0;
            level_d = sample;
        end else begin
            unique case (state_q)
                FLT_IDLE: begin
                    if (sample != level_q && tick) begin          // start
                        state_d = FLT_VERIFY;
                        cnt_d   = CNT_W'(1);
                    end
                end
                FLT_VERIFY: begin
                    if (sample == level_q) begin                  // abort
                        state_d = FLT_IDLE;
                        cnt_d   = '0;
                    end else if (tick) begin
                        if (cnt_q + CNT_W'(1) == need) begin      // accept
                            state_d  = FLT_IDLE;
                            cnt_d    = '0;
                            level_d  = ~level_q;
                            change_d = 1'b1;
                        end else begin                            // hold
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    state_d = FLT_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign level  = level_q;
    assign change = change_q;
endmodule

// File: rtl/pin_debounce_top.sv
module pin_debounce_top import pdb_pkg::*; #(
    parameter  int NUM_GROUPS     = 2,
    parameter  int PINS_PER_GROUP = 8,
    parameter  int SYNC_STAGES    = 2,
    localparam int NUM_PINS       = NUM_GROUPS * PINS_PER_GROUP,
    localparam int REG_W          = 32,
    localparam int GRP_BITS       = NUM_GROUPS * GRP_FIELD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                lf_tick,
    input  logic                cfg_we,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic [NUM_PINS-1:0] pins_in,
    output logic [NUM_PINS-1:0] pins_level,
    output logic [NUM_PINS-1:0] pins_change
);
    grp_cfg_t [NUM_GROUPS-1:0] grp_cfg_q;
    logic                      src_sel_q;
    logic [NUM_GROUPS-1:0]     grp_tick;
    logic [NUM_PINS-1:0]       sync_q;
    logic                      step;
    logic                      unused_wbits;

    assign unused_wbits = ^{cfg_wdata[REG_W-1:SRC_SEL_BIT+1],
                            cfg_wdata[SRC_SEL_BIT-1:GRP_BITS]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_cfg_q <= '0;
            src_sel_q <= 1'b0;
        end else if (cfg_we && !enable) begin
            grp_cfg_q <= cfg_wdata[GRP_BITS-1:0];
            src_sel_q <= cfg_wdata[SRC_SEL_BIT];
        end
    end

    always_comb begin
        cfg_rdata                 = '0;
        cfg_rdata[GRP_BITS-1:0]   = grp_cfg_q;
        cfg_rdata[SRC_SEL_BIT]    = src_sel_q;
    end

    assign step = src_sel_q ? lf_tick : 1'b1;

    pdb_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_in),
        .q    (sync_q)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        pdb_prescaler u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .enable(enable),
            .step  (step),
            .code  (grp_cfg_q[g].div_code),
            .tick  (grp_tick[g])
        );
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int G = p / PINS_PER_GROUP;
        pdb_pin_filter u_flt (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable      (enable),
            .tick        (grp_tick[G]),
            .sample      (sync_q[p]),
            .many_samples(grp_cfg_q[G].many_samples),
            .level       (pins_level[p]),
            .change      (pins_change[p])
        );
    end
endmodule

// File: rtl/pin_debounce_checker.sv
module pin_debounce_checker import pdb_pkg::*; #(
    parameter  int NUM_GROUPS     = 2,
    parameter  int PINS_PER_GROUP = 8,
    localparam int NUM_PINS       = NUM_GROUPS * PINS_PER_GROUP,
    localparam int REG_W          = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic [REG_W-1:0]      cfg_rdata,
    input logic [NUM_PINS-1:0]   pins_level,
    input logic [NUM_PINS-1:0]   pins_change,
    input logic [NUM_GROUPS-1:0] grp_tick
);
    localparam logic [REG_W-1:0] LIVE_MASK =
        ((REG_W'(1) << (NUM_GROUPS * GRP_FIELD_W)) - REG_W'(1)) | (REG_W'(1) << SRC_SEL_BIT);

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~LIVE_MASK) == '0)
        else $error("reserved configuration bits set");

    assert_locked_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> $stable(cfg_rdata))
        else $error("configuration changed while enabled");

    assert_pulse_marks_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> (pins_change == (pins_level ^ $past(pins_level))))
        else $error("change pulse does not match level flip");

    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (pins_change == '0))
        else $error("change pulse while disabled");

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        localparam int G = p / PINS_PER_GROUP;
        assert_pulse_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pins_change[p] |-> $past(grp_tick[G]))
            else $error("flip without a group tick");
    end
endmodule

bind pin_debounce_top pin_debounce_checker #(
    .NUM_GROUPS    (NUM_GROUPS),
    .PINS_PER_GROUP(PINS_PER_GROUP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_rdata  (cfg_rdata),
    .pins_level (pins_level),
    .pins_change(pins_change),
    .grp_tick   (grp_tick)
);

// File: tb/tb_pin_debounce_top.sv
module tb_pin_debounce_top;
    localparam int NG  = 2;
    localparam int PPG = 8;
    localparam int NP  = NG * PPG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          lf_tick = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NP-1:0] pins_in = '0;
    logic [NP-1:0] pins_level;
    logic [NP-1:0] pins_change;

    int n_tests = 0;
    int n_fail  = 0;
    int gcyc    = 0;
    int total_pulses = 0;

    // Reference state from the requirements
    logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_lvl = '0, m_pulse = '0;
    int m_ctr[NP];
    int m_cnt[NG];
    int m_code[NG];
    int m_ns[NG];
    int m_src = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        gcyc    <= gcyc + 1;
        lf_tick <= (gcyc % 2 == 0);
    end

    pin_debounce_top dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .lf_tick(lf_tick),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pins_in(pins_in), .pins_level(pins_level), .pins_change(pins_change)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_cycle();
        int  step, mask, need, g;
        bit  tk[NG];
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_lvl = '0; m_pulse = '0; m_src = 0;
            for (int i = 0; i < NP; i++) m_ctr[i] = 0;
            for (int j = 0; j < NG; j++) begin m_cnt[j] = 0; m_code[j] = 0; m_ns[j] = 0; end
        end else begin
            step = (m_src == 1) ? int'(lf_tick) : 1;
            for (int j = 0; j < NG; j++) begin
                mask  = (2 << m_code[j]) - 1;
                tk[j] = enable && (step == 1) && ((m_cnt[j] & mask) == mask);
                m_cnt[j] = enable ? ((m_cnt[j] + step) % 256) : 0;
            end
            for (int i = 0; i < NP; i++) begin
                g    = i / PPG;
                need = (m_ns[g] == 1) ? 7 : 3;
                m_pulse[i] = 1'b0;
                if (!enable) begin
                    m_lvl[i] = m_s2[i];
                    m_ctr[i] = 0;
                end else if (m_s2[i] == m_lvl[i]) begin
                    m_ctr[i] = 0;
                end else if (tk[g]) begin
                    if (m_ctr[i] + 1 == need) begin
                        m_lvl[i]   = ~m_lvl[i];
                        m_ctr[i]   = 0;
                        m_pulse[i] = 1'b1;
                    end else begin
                        m_ctr[i] = m_ctr[i] + 1;
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = pins_in;
            if (cfg_we && !enable) begin
                m_code[0] = int'(cfg_wdata[2:0]); m_ns[0] = int'(cfg_wdata[3]);
                m_code[1] = int'(cfg_wdata[6:4]); m_ns[1] = int'(cfg_wdata[7]);
                m_src     = int'(cfg_wdata[16]);
            end
        end
        @(negedge clk);
        total_pulses += $countones(m_pulse);
        chk(pins_level === m_lvl, "R1 R2 R3 R7 R8 R9", "pins_level",
            32'(pins_level), 32'(m_lvl));
        chk(pins_change === m_pulse, "R10 R11", "pins_change",
            32'(pins_change), 32'(m_pulse));
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R5 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int H, hold, pulses;
        logic [31:0] word;

        // R5: reset state
        repeat (3) do_cycle();
        rst_n = 1'b1;
        do_cycle();
        chk(cfg_rdata === 32'h0, "R5", "cfg_rdata after reset", cfg_rdata, 32'h0);
        chk(pins_level === '0, "R5", "levels after reset", 32'(pins_level), 32'h0);
        chk(pins_change === '0, "R5", "pulses after reset", 32'(pins_change), 32'h0);

        // R4: reserved bits read zero, fields at fixed positions
        cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF; do_cycle();
        cfg_we = 1'b0; do_cycle();
        chk(cfg_rdata === 32'h0001_00FF, "R4", "all-ones write readback", cfg_rdata, 32'h0001_00FF);
        cfg_we = 1'b1; cfg_wdata = 32'h0000_00A5; do_cycle();
        cfg_we = 1'b0; do_cycle();
        chk(cfg_rdata === 32'h0000_00A5, "R1 R4", "per-group field readback", cfg_rdata, 32'h0000_00A5);

        // R6: write while enabled is ignored
        enable = 1'b1; do_cycle();
        cfg_we = 1'b1; cfg_wdata = 32'h0001_005A; do_cycle();
        cfg_we = 1'b0; do_cycle();
        chk(cfg_rdata === 32'h0000_00A5, "R6", "locked write", cfg_rdata, 32'h0000_00A5);
        enable = 1'b0; do_cycle();

        // R8 R11: disabled path latency
        pins_in = 16'h00F0;
        do_cycle(); do_cycle();
        chk(pins_level === 16'h0000, "R8", "level after two edges", 32'(pins_level), 32'h0);
        do_cycle();
        chk(pins_level === 16'h00F0, "R8 R11", "level after three edges", 32'(pins_level), 32'h00F0);
        chk(pins_change === '0, "R11", "no pulse while disabled", 32'(pins_change), 32'h0);
        pins_in = '0;
        repeat (3) do_cycle();

        // Sweep: every code, both sample counts, both sources; groups opposite counts
        for (int src = 0; src < 2; src++) begin
            for (int ns = 0; ns < 2; ns++) begin
                for (int k = 0; k < 8; k++) begin
                    enable = 1'b0;
                    word = (32'(src) << 16) | (32'(ns ^ 1) << 7) | (32'(k) << 4) | (32'(ns) << 3) | 32'(k);
                    cfg_we = 1'b1; cfg_wdata = word; do_cycle();
                    cfg_we = 1'b0; pins_in = '0;
                    repeat (3) do_cycle();
                    chk(cfg_rdata === word, "R4 R6", "sweep config readback", cfg_rdata, word);
                    enable = 1'b1;
                    H = 8 * (2 << k) * ((src == 1) ? 2 : 1);
                    for (int r = 0; r < 3 * H; r++) begin
                        for (int i = 0; i < NP; i++) begin
                            hold = (H / 8) * ((i % 8) + 1);
                            if ((r + 3 * i) % hold == 0) pins_in[i] = ~pins_in[i];
                        end
                        do_cycle();
                    end
                end
            end
        end
        chk(total_pulses > 0, "R10", "accepted transitions seen", 32'(total_pulses), 32'h1);

        // R9: repeated glitches of two ticks with a three-tick requirement
        enable = 1'b0;
        cfg_we = 1'b1; cfg_wdata = 32'h0; do_cycle();
        cfg_we = 1'b0; pins_in = '0;
        repeat (3) do_cycle();
        enable = 1'b1;
        pulses = 0;
        repeat (5) begin
            pins_in[0] = 1'b1;
            repeat (4) begin do_cycle(); pulses += int'(pins_change[0]); end
            pins_in[0] = 1'b0;
            repeat (4) begin do_cycle(); pulses += int'(pins_change[0]); end
        end
        chk(pulses == 0, "R9", "glitch train pulses", 32'(pulses), 32'h0);
        chk(pins_level[0] === 1'b0, "R9", "glitch train level", 32'(pins_level[0]), 32'h0);

        // R3 R10: a steady level is accepted with exactly one pulse
        pulses = 0;
        pins_in[0] = 1'b1;
        repeat (12) begin do_cycle(); pulses += int'(pins_change[0]); end
        chk(pulses == 1, "R3 R10", "steady change pulses", 32'(pulses), 32'h1);
        chk(pins_level[0] === 1'b1, "R3", "steady change level", 32'(pins_level[0]), 32'h1);

        summary();
        $finish;
    end
endmodule